// File: doc/BRIEF.md
# Big-endian host window bridge

This block sits between a 32-bit big-endian host bus and the little-endian local side of a communication board. A single host request (byte offset, write data, four-bit byte mask and a read/write flag) is decoded into one of three local regions: a byte-wide shared communication RAM, a 16-bit register file and the 16-bit RAM of the local processor. Offsets that fall in none of the regions complete without touching the local side.

For the communication RAM the bridge splits the host word into single-byte accesses, one for each enabled lane, and applies an address swizzle (local byte address = host byte offset XOR 3) so that the big-endian host sees bytes in its own order. For the two 16-bit regions the item travels on the upper half of the host bus; its two bytes and the two matching mask bits are exchanged in each direction. Every local port answers one cycle after its request; the bridge collects the answers and reports completion with a one-cycle done pulse.

The control is a four-state machine. IDLE (ready high) accepts a request, latches it, and moves to ISSUE when local work is needed, otherwise directly to RESP. ISSUE drives exactly one local request and always moves to CAPTURE. CAPTURE stores the returned data; it goes back to ISSUE while communication RAM lanes are still pending, and to RESP otherwise. RESP raises done for one cycle and returns to IDLE.

Top module: `be_host_bridge`

## Requirements
- R1: Each communication RAM access uses local byte address equal to the host byte offset of its lane XOR 3, where lane k (host offset low bits = k) carries host data bits [31-8k:24-8k] and is enabled by host mask bit 3-k.
- R2: A request to offsets 0x00000-0x0FFFF produces one local byte access per enabled lane, in ascending host offset order, one access every two cycles; with no lane enabled no access is made.
- R3: A communication RAM read returns each fetched byte in the lane it was requested on; lanes not enabled read as zero.
- R4: Offsets 0x10000-0x101FF address the register file with item index equal to host offset bits [8:2]; write data is host bits [31:16] with its two bytes exchanged.
- R5: Offsets 0x20000-0x3FFFF address the local RAM with item index equal to host offset bits [16:2], using the same byte exchange as R4.
- R6: The local two-bit mask for both 16-bit regions is {host mask bit 2, host mask bit 3}, so local mask bit 0 guards local bits [7:0].
- R7: A read of either 16-bit region returns the local item with its bytes exchanged on host bits [31:16], and zero on host bits [15:0].
- R8: A request at any offset outside the three regions issues no local request; a read returns zero.
- R9: Ready is high only in IDLE; done is a single-cycle pulse. Done appears 1 cycle after acceptance for out-of-region or no-lane requests, 3 cycles for 16-bit regions and 2n+1 cycles for n enabled communication RAM lanes.
- R10: After reset ready is high, done is low and no local request is active.
- R11: At most one local port is requested in any cycle.
- R12: Writing a 16-bit region item and reading it back returns the original host value on bits [31:16], because the exchange applied twice is the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_req | input | 1 | Host request, taken when hst_ready is high |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_addr | input | HADDR_W | Host byte offset into the window |
| hst_wdata | input | 32 | Host write data, big-endian lanes |
| hst_be | input | 4 | Host byte mask, bit 3 = lowest offset |
| hst_ready | output | 1 | Bridge idle and able to take a request |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Read data, valid while hst_done is high |
| cram_req | output | 1 | Communication RAM byte request |
| cram_we | output | 1 | Communication RAM write |
| cram_addr | output | CRAM_AW | Communication RAM byte address |
| cram_wdata | output | 8 | Communication RAM write byte |
| cram_rdata | input | 8 | Communication RAM read byte, one cycle after request |
| reg_req | output | 1 | Register file request |
| reg_we | output | 1 | Register file write |
| reg_idx | output | REG_AW | Register index |
| reg_wdata | output | 16 | Register write data |
| reg_be | output | 2 | Register byte mask |
| reg_rdata | input | 16 | Register read data, one cycle after request |
| lram_req | output | 1 | Local RAM request |
| lram_we | output | 1 | Local RAM write |
| lram_idx | output | LRAM_AW | Local RAM item index |
| lram_wdata | output | 16 | Local RAM write data |
| lram_be | output | 2 | Local RAM byte mask |
| lram_rdata | input | 16 | Local RAM read data, one cycle after request |

## Verification
Every result has a fixed due cycle counted from the clock edge that accepts the request: done and read data one cycle later for out-of-region and empty-mask requests, three cycles later for the 16-bit regions and 2n+1 cycles later for n communication RAM lanes. The bench drives and samples on the falling edge, counts falling edges from acceptance until done, and compares that count with the due value, so a late or early response fails even when its data is right. Local requests are logged by port models that answer on the edge after each request, and the log is checked for address, data, mask and order once the access has completed.

// File: rtl/be_bridge_pkg.sv
package be_bridge_pkg;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_CRAM,
        RGN_REGS,
        RGN_LRAM
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_CAPTURE,
        ST_RESP
    } state_e;

    // exchange the two bytes of a 16-bit item
    function automatic logic [15:0] swap16(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    // exchange the two mask bits belonging to a 16-bit item
    function automatic logic [1:0] swap_be(input logic [1:0] m);
        return {m[0], m[1]};
    endfunction

endpackage

// File: rtl/be_region_decode.sv
module be_region_decode
    import be_bridge_pkg::*;
#(
    parameter int HADDR_W = 18,
    parameter int CRAM_AW = 16,
    parameter int REG_AW  = 7,
    parameter int LRAM_AW = 15
) (
    input  logic [HADDR_W-1:0] addr,
    output region_e            region
);
    localparam logic [31:0] CRAM_END  = 32'(1) << CRAM_AW;
    localparam logic [31:0] REG_BASE  = CRAM_END;
    localparam logic [31:0] REG_END   = REG_BASE + (32'(4) << REG_AW);
    localparam logic [31:0] LRAM_BASE = 32'(2) << CRAM_AW;
    localparam logic [31:0] LRAM_END  = LRAM_BASE + (32'(4) << LRAM_AW);

    logic [31:0] a;

    always_comb begin
        a = 32'(addr);
        if (a < CRAM_END)
            region = RGN_CRAM;
        else if (a >= REG_BASE && a < REG_END)
            region = RGN_REGS;
        else if (a >= LRAM_BASE && a < LRAM_END)
            region = RGN_LRAM;
        else
            region = RGN_NONE;
    end
endmodule

// File: rtl/be_lane_pick.sv
module be_lane_pick #(
    parameter int LANES = 4,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] pend,
    output logic [LANES-1:0] sel,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [LANES:0] lower;

    assign lower[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            assign lower[k+1] = lower[k] | pend[k];
            assign sel[k]     = pend[k] & ~lower[k];
        end
    endgenerate

    assign any = lower[LANES];

    always_comb begin
        idx = '0;
        for (int j = LANES - 1; j >= 0; j--) begin
            if (pend[j])
                idx = IDX_W'(j);
        end
    end
endmodule

// File: rtl/be_host_bridge.sv
module be_host_bridge
    import be_bridge_pkg::*;
#(
    parameter int HADDR_W = 18,
    parameter int CRAM_AW = 16,
    parameter int REG_AW  = 7,
    parameter int LRAM_AW = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [HADDR_W-1:0] hst_addr,
    input  logic [31:0]        hst_wdata,
    input  logic [3:0]         hst_be,
    output logic               hst_ready,
    output logic               hst_done,
    output logic [31:0]        hst_rdata,
    output logic               cram_req,
    output logic               cram_we,
    output logic [CRAM_AW-1:0] cram_addr,
    output logic [7:0]         cram_wdata,
    input  logic [7:0]         cram_rdata,
    output logic               reg_req,
    output logic               reg_we,
    output logic [REG_AW-1:0]  reg_idx,
    output logic [15:0]        reg_wdata,
    output logic [1:0]         reg_be,
    input  logic [15:0]        reg_rdata,
    output logic               lram_req,
    output logic               lram_we,
    output logic [LRAM_AW-1:0] lram_idx,
    output logic [15:0]        lram_wdata,
    output logic [1:0]         lram_be,
    input  logic [15:0]        lram_rdata
);
    localparam int LANES = 4;
    localparam int LW    = $clog2(LANES);
    localparam int WA_W  = LRAM_AW;

    state_e            state_q, state_d;
    region_e           rgn_dec, rgn_q;
    logic              we_q;
    logic [WA_W-1:0]   wa_q;
    logic [31:0]       wdata_q;
    logic [1:0]        be_hi_q;
    logic [LANES-1:0]  pend_q;
    logic [LW-1:0]     lane_q;
    logic [31:0]       acc_q;
    logic [LANES-1:0]  pick_sel;
    logic [LW-1:0]     pick_idx;
    logic              pick_any;
    logic [LANES-1:0]  pend_in;
    logic              accept;

    be_region_decode #(
        .HADDR_W (HADDR_W),
        .CRAM_AW (CRAM_AW),
        .REG_AW  (REG_AW),
        .LRAM_AW (LRAM_AW)
    ) u_dec (
        .addr   (hst_addr),
        .region (rgn_dec)
    );

    be_lane_pick #(
        .LANES (LANES)
    ) u_pick (
        .pend (pend_q),
        .sel  (pick_sel),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    // lane k (host offset k) is enabled by mask bit 3-k
    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_pend
            assign pend_in[k] = hst_be[LANES-1-k];
        end
    endgenerate

    assign accept = (state_q == ST_IDLE) && hst_req;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hst_req) begin
                    if (rgn_dec == RGN_NONE)
                        state_d = ST_RESP;
                    else if (rgn_dec == RGN_CRAM && pend_in == '0)
                        state_d = ST_RESP;
                    else
                        state_d = ST_ISSUE;
                end
            end
            ST_ISSUE:   state_d = ST_CAPTURE;
            ST_CAPTURE: begin
                if (rgn_q == RGN_CRAM && pend_q != '0)
                    state_d = ST_ISSUE;
                else
                    state_d = ST_RESP;
            end
            ST_RESP:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // request latch and data collection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgn_q   <= RGN_NONE;
            we_q    <= 1'b0;
            wa_q    <= '0;
            wdata_q <= '0;
            be_hi_q <= '0;
            pend_q  <= '0;
            lane_q  <= '0;
            acc_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rgn_q   <= rgn_dec;
                        we_q    <= hst_we;
                        wa_q    <= hst_addr[WA_W+1:2];
                        wdata_q <= hst_wdata;
                        be_hi_q <= hst_be[3:2];
                        pend_q  <= pend_in;
                        acc_q   <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (rgn_q == RGN_CRAM) begin
                        lane_q <= pick_idx;
                        pend_q <= pend_q & ~pick_sel;
                    end
                end
                ST_CAPTURE: begin
                    if (!we_q) begin
                        unique case (rgn_q)
                            RGN_CRAM: acc_q[8*(LANES-1-int'(lane_q)) +: 8] <= cram_rdata;
                            RGN_REGS: acc_q[31:16] <= swap16(reg_rdata);
                            RGN_LRAM: acc_q[31:16] <= swap16(lram_rdata);
                            default:  acc_q <= acc_q;
                        endcase
                    end
                end
                ST_RESP: begin
                    pend_q <= '0;
                end
                default: begin
                    pend_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        hst_ready  = 1'b0;
        hst_done   = 1'b0;
        hst_rdata  = '0;
        cram_req   = 1'b0;
        reg_req    = 1'b0;
        lram_req   = 1'b0;
        unique case (state_q)
            ST_IDLE:    hst_ready = 1'b1;
            ST_ISSUE: begin
                cram_req = (rgn_q == RGN_CRAM) && pick_any;
                reg_req  = (rgn_q == RGN_REGS);
                lram_req = (rgn_q == RGN_LRAM);
            end
            ST_CAPTURE: hst_ready = 1'b0;
            ST_RESP: begin
                hst_done  = 1'b1;
                hst_rdata = acc_q;
            end
            default:    hst_ready = 1'b0;
        endcase
    end

    assign cram_we    = we_q;
    assign cram_addr  = {wa_q[CRAM_AW-3:0], ~pick_idx};
    assign cram_wdata = wdata_q[8*(LANES-1-int'(pick_idx)) +: 8];

    assign reg_we     = we_q;
    assign reg_idx    = wa_q[REG_AW-1:0];
    assign reg_wdata  = swap16(wdata_q[31:16]);
    assign reg_be     = swap_be(be_hi_q);

    assign lram_we    = we_q;
    assign lram_idx   = wa_q[LRAM_AW-1:0];
    assign lram_wdata = swap16(wdata_q[31:16]);
    assign lram_be    = swap_be(be_hi_q);

    // R11
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cram_req, reg_req, lram_req}));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_done |=> !hst_done && hst_ready);

    // R8
    void_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_ready && hst_req && rgn_dec == RGN_NONE)
            |=> hst_done && !(cram_req || reg_req || lram_req));

    // R2
    cram_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cram_req |=> !cram_req && !hst_done);

    // R9
    busy_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req || lram_req) |=> !hst_ready && !hst_done);
endmodule

// File: tb/be_host_bridge_test.sv
module be_host_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        hst_req, hst_we;
    logic [17:0] hst_addr;
    logic [31:0] hst_wdata;
    logic [3:0]  hst_be;
    logic        hst_ready, hst_done;
    logic [31:0] hst_rdata;
    logic        cram_req, cram_we;
    logic [15:0] cram_addr;
    logic [7:0]  cram_wdata, cram_rdata;
    logic        reg_req, reg_we;
    logic [6:0]  reg_idx;
    logic [15:0] reg_wdata, reg_rdata;
    logic [1:0]  reg_be;
    logic        lram_req, lram_we;
    logic [14:0] lram_idx;
    logic [15:0] lram_wdata, lram_rdata;
    logic [1:0]  lram_be;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    be_host_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_be(hst_be),
        .hst_ready(hst_ready), .hst_done(hst_done), .hst_rdata(hst_rdata),
        .cram_req(cram_req), .cram_we(cram_we), .cram_addr(cram_addr),
        .cram_wdata(cram_wdata), .cram_rdata(cram_rdata),
        .reg_req(reg_req), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .lram_req(lram_req), .lram_we(lram_we), .lram_idx(lram_idx),
        .lram_wdata(lram_wdata), .lram_be(lram_be), .lram_rdata(lram_rdata)
    );

    // local port models with one-cycle response, plus request logs
    logic [7:0]  cmem [0:255];
    logic [15:0] rmem [0:127];
    logic [15:0] lmem [0:255];
    logic [15:0] clog_a [0:255];
    logic [7:0]  clog_d [0:255];
    int          clog_n = 0;
    int          reg_cnt = 0, lram_cnt = 0;
    logic [15:0] last_wd;
    logic [1:0]  last_be;
    logic [14:0] last_idx;

    initial begin
        for (int i = 0; i < 256; i++) begin
            cmem[i] = 8'h00;
            lmem[i] = 16'h0000;
        end
        for (int i = 0; i < 128; i++) rmem[i] = 16'h0000;
    end

    always @(posedge clk) begin
        if (cram_req) begin
            clog_a[clog_n[7:0]] <= cram_addr;
            clog_d[clog_n[7:0]] <= cram_wdata;
            clog_n <= clog_n + 1;
            if (cram_we) cmem[cram_addr[7:0]] <= cram_wdata;
            cram_rdata <= cmem[cram_addr[7:0]];
        end
        if (reg_req) begin
            reg_cnt  <= reg_cnt + 1;
            last_wd  <= reg_wdata;
            last_be  <= reg_be;
            last_idx <= {8'h00, reg_idx};
            if (reg_we && reg_be[0]) rmem[reg_idx][7:0]  <= reg_wdata[7:0];
            if (reg_we && reg_be[1]) rmem[reg_idx][15:8] <= reg_wdata[15:8];
            reg_rdata <= rmem[reg_idx];
        end
        if (lram_req) begin
            lram_cnt <= lram_cnt + 1;
            last_wd  <= lram_wdata;
            last_be  <= lram_be;
            last_idx <= lram_idx;
            if (lram_we && lram_be[0]) lmem[lram_idx[7:0]][7:0]  <= lram_wdata[7:0];
            if (lram_we && lram_be[1]) lmem[lram_idx[7:0]][15:8] <= lram_wdata[15:8];
            lram_rdata <= lmem[lram_idx[7:0]];
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [17:0] a, input logic w, input logic [31:0] d,
                          input logic [3:0] b, output logic [31:0] rd, output int lat);
        @(negedge clk);
        hst_req = 1'b1; hst_we = w; hst_addr = a; hst_wdata = d; hst_be = b;
        @(negedge clk);
        hst_req = 1'b0;
        lat = 1;
        while (!hst_done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        rd = hst_rdata;
    endtask

    task automatic t_reset();
        check("R10 ready", 32'(hst_ready), 32'd1);
        check("R10 done", 32'(hst_done), 32'd0);
        check("R10 reqs", 32'({cram_req, reg_req, lram_req}), 32'd0);
    endtask

    task automatic t_cram_single();
        logic [31:0] rd; int lat; int base;
        base = clog_n;
        access(18'h00105, 1'b1, 32'h00A50000, 4'b0100, rd, lat);
        check("R9 cram 1-lane latency", 32'(lat), 32'd3);
        check("R2 cram 1-lane count", 32'(clog_n - base), 32'd1);
        check("R1 cram addr xor3", 32'(clog_a[base[7:0]]), 32'h106);
        check("R1 cram lane data", 32'(clog_d[base[7:0]]), 32'hA5);
    endtask

    task automatic t_cram_word();
        logic [31:0] rd; int lat; int base;
        base = clog_n;
        access(18'h00200, 1'b1, 32'h11223344, 4'b1111, rd, lat);
        check("R9 cram 4-lane latency", 32'(lat), 32'd9);
        check("R2 cram 4-lane count", 32'(clog_n - base), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R1 cram word addr", 32'(clog_a[8'(base + i)]), 32'h200 + 32'(3 - i));
            check("R2 cram order data", 32'(clog_d[8'(base + i)]), 32'(8'h11 + 8'(i * 'h11)));
        end
    endtask

    task automatic t_cram_read();
        logic [31:0] rd; int lat; int base;
        access(18'h00200, 1'b0, 32'hFFFFFFFF, 4'b1111, rd, lat);
        check("R3 cram full read", rd, 32'h11223344);
        access(18'h00200, 1'b0, 32'h0, 4'b0101, rd, lat);
        check("R3 cram partial read", rd, 32'h00220044);
        check("R9 cram 2-lane latency", 32'(lat), 32'd5);
        base = clog_n;
        access(18'h00200, 1'b0, 32'h0, 4'b0000, rd, lat);
        check("R2 cram empty mask count", 32'(clog_n - base), 32'd0);
        check("R3 cram empty read", rd, 32'h0);
        check("R9 cram empty latency", 32'(lat), 32'd1);
    endtask

    task automatic t_regs();
        logic [31:0] rd; int lat; int base;
        base = reg_cnt;
        access(18'h10008, 1'b1, 32'hBEEF1234, 4'b1100, rd, lat);
        check("R9 reg latency", 32'(lat), 32'd3);
        check("R4 reg count", 32'(reg_cnt - base), 32'd1);
        check("R4 reg index", 32'(last_idx), 32'd2);
        check("R4 reg swapped data", 32'(last_wd), 32'hEFBE);
        check("R6 reg full mask", 32'(last_be), 32'd3);
        access(18'h10008, 1'b0, 32'h0, 4'b1100, rd, lat);
        check("R12 reg round trip", rd, 32'hBEEF0000);
        access(18'h1000C, 1'b1, 32'hAB000000, 4'b1000, rd, lat);
        check("R6 reg mask bit3", 32'(last_be), 32'd1);
        access(18'h1000C, 1'b1, 32'h00CD0000, 4'b0100, rd, lat);
        check("R6 reg mask bit2", 32'(last_be), 32'd2);
        access(18'h1000C, 1'b0, 32'h0, 4'b1100, rd, lat);
        check("R7 reg merged read", rd, 32'hABCD0000);
        access(18'h101FC, 1'b1, 32'h600D0000, 4'b1100, rd, lat);
        check("R4 reg last index", 32'(last_idx), 32'd127);
        access(18'h101FC, 1'b0, 32'h0, 4'b1100, rd, lat);
        check("R12 reg last round trip", rd, 32'h600D0000);
    endtask

    task automatic t_lram();
        logic [31:0] rd; int lat; int base;
        base = lram_cnt;
        access(18'h3FFFC, 1'b1, 32'h1357FFFF, 4'b1111, rd, lat);
        check("R5 lram count", 32'(lram_cnt - base), 32'd1);
        check("R5 lram top index", 32'(last_idx), 32'h7FFF);
        check("R5 lram swapped data", 32'(last_wd), 32'h5713);
        check("R9 lram latency", 32'(lat), 32'd3);
        access(18'h3FFFC, 1'b0, 32'h0, 4'b1111, rd, lat);
        check("R7 lram read low half zero", rd, 32'h13570000);
        access(18'h20004, 1'b1, 32'h24680000, 4'b1100, rd, lat);
        check("R5 lram index 1", 32'(last_idx), 32'd1);
        access(18'h20004, 1'b0, 32'h0, 4'b1100, rd, lat);
        check("R12 lram round trip", rd, 32'h24680000);
    endtask

    task automatic t_void();
        logic [31:0] rd; int lat; int b0, b1, b2;
        b0 = clog_n; b1 = reg_cnt; b2 = lram_cnt;
        access(18'h10200, 1'b0, 32'h0, 4'b1111, rd, lat);
        check("R8 void read zero", rd, 32'h0);
        check("R9 void latency", 32'(lat), 32'd1);
        access(18'h1FFFC, 1'b1, 32'hDEADBEEF, 4'b1111, rd, lat);
        check("R8 void write no request",
              32'((clog_n - b0) + (reg_cnt - b1) + (lram_cnt - b2)), 32'd0);
        access(18'h10200, 1'b1, 32'hDEADBEEF, 4'b1111, rd, lat);
        access(18'h101FC, 1'b0, 32'h0, 4'b1100, rd, lat);
        check("R8 void write left regs intact", rd, 32'h600D0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=hung expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        hst_req = 1'b0; hst_we = 1'b0; hst_addr = '0; hst_wdata = '0; hst_be = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cram_single();
        t_cram_word();
        t_cram_read();
        t_regs();
        t_lram();
        t_void();
        repeat (2) @(negedge clk);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule